// File: doc/BRIEF.md
# Functional/Test Mode Tile Wrapper

This block sits between a network interface and one processor tile. Every word that arrives from the network is either a command or data. A dedicated flag marks command words. Commands move the tile between ordinary operation and scan-test operation.

In functional mode, data words reach the tile's functional inputs unchanged, and the tile's functional results return to the network unchanged. In test mode, each 32-bit data word becomes one shift cycle: bit i of the word is driven into scan chain i, and the same word is held on the tile's primary inputs. The bits that leave the chains in that cycle are packed into one 32-bit response word.

After a parameterised number of shift words, the wrapper opens a one-cycle capture slot with scan enable low. The next response word carries the tile's primary outputs as they stood in that slot. While the tile is under test, its functional traffic never reaches the network.

Top module: `tile_mode_wrapper`

## Requirements
- R1: While reset is asserted, and right after it, tile_test_mode, scan_enable, scan_capture, tile_in_valid and net_out_valid are all low.
- R2: In functional mode, a data word (net_in_valid=1, net_in_is_cmd=0) appears on tile_in_word with tile_in_valid=1 one clock after the edge that samples it.
- R3: In functional mode, tile_out_valid/tile_out_word appear on net_out_valid/net_out_word one clock after the edge that samples them.
- R4: A command word has net_in_is_cmd=1, and its opcode is net_in_word[1:0]: 0 does nothing, 1 enters test mode, 2 leaves test mode, 3 requests a capture. tile_test_mode changes one clock after the edge that samples the command. A command word never raises tile_in_valid.
- R5: In test mode, each data word raises scan_enable for exactly the one cycle after its sampling edge. In that cycle, scan_in_bits[i] equals word bit i and tile_in_word holds the word. tile_in_valid stays low.
- R6: For every shift cycle, net_out_valid is high one clock later and net_out_word equals scan_out_bits as driven during that shift cycle.
- R7: In test mode, tile_out_valid never reaches the network. net_out_valid is low after any test-mode cycle that is neither a shift cycle nor a capture slot.
- R8: After SHIFT_WORDS shift words, scan_capture is high with scan_enable low for the one cycle that follows the last shift cycle.
- R9: A data word sampled at the edge that opens a capture slot is discarded. It causes no shift, does not load scan_in_bits, and does not advance the word count.
- R10: One clock after a capture slot, net_out_valid is high and net_out_word equals tile_out_word as driven during that slot.
- R11: A capture command in test mode opens a capture slot in the next cycle and restarts the word count. Capture and leave commands in functional mode have no effect.
- R12: A leave command returns the tile to functional mode and cancels a capture slot that was due at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| net_in_valid | input | 1 | Network word present |
| net_in_is_cmd | input | 1 | Marks the incoming word as a command |
| net_in_word | input | WORD_W | Incoming network word |
| net_out_valid | output | 1 | Outgoing word present |
| net_out_word | output | WORD_W | Outgoing functional result or test response |
| tile_in_valid | output | 1 | Functional input strobe to the tile |
| tile_in_word | output | WORD_W | Functional input in functional mode, primary inputs in test mode |
| tile_out_valid | input | 1 | Functional output strobe from the tile |
| tile_out_word | input | WORD_W | Functional output, or primary outputs in test mode |
| tile_test_mode | output | 1 | Tile is under test |
| scan_enable | output | 1 | Shift enable for all chains |
| scan_capture | output | 1 | Capture slot indicator |
| scan_in_bits | output | WORD_W | One input bit per scan chain |
| scan_out_bits | input | WORD_W | One output bit per scan chain |

## Verification
Each result has a fixed latency counted in edges. Tile inputs, mode changes and scan enable follow the sampling edge by one clock. A shift response follows its shift cycle by one clock. The capture slot falls two edges after the last word, and its primary-output response comes one edge after the slot. The bench changes inputs just after a falling edge and reads outputs at the next falling edge, so every check lands on the exact cycle the requirement names. Tile-side values such as scan_out_bits are set during the cycle in which the wrapper is meant to sample them.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NONE    = 2'd0,
    OP_ENTER   = 2'd1,
    OP_LEAVE   = 2'd2,
    OP_CAPTURE = 2'd3
  } op_e;

  typedef struct packed {
    logic data;
    logic enter;
    logic leave;
    logic capture;
  } strobe_t;
endpackage

// File: rtl/tw_rst_sync.sv
module tw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/tw_cmd_decode.sv
module tw_cmd_decode
  import tw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_is_cmd,
  input  logic [OP_W-1:0] op_bits,
  output strobe_t         stb_o,
  output logic            test_mode_o
);
  op_e     op;
  strobe_t stb;
  logic    mode_q, mode_d;

  always_comb begin
    op          = op_e'(op_bits);
    stb.data    = in_valid & ~in_is_cmd;
    stb.enter   = in_valid & in_is_cmd & (op == OP_ENTER) & ~mode_q;
    stb.leave   = in_valid & in_is_cmd & (op == OP_LEAVE) & mode_q;
    stb.capture = in_valid & in_is_cmd & (op == OP_CAPTURE) & mode_q;
  end

  always_comb begin
    mode_d = mode_q;
    if (stb.enter)      mode_d = 1'b1;
    else if (stb.leave) mode_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_d;
  end

  assign stb_o       = stb;
  assign test_mode_o = mode_q;

  // R4: an enter command is in effect from the next cycle
  p_enter_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_cmd && op_bits == OP_ENTER) |=> test_mode_o);
endmodule

// File: rtl/tw_scan_seq.sv
module tw_scan_seq
  import tw_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int SHIFT_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb_i,
  input  logic              mode_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              tile_valid_o,
  output logic [WORD_W-1:0] tile_word_o,
  output logic              scan_en_o,
  output logic              capture_o
);
  localparam int CNT_W = (SHIFT_WORDS > 1) ? $clog2(SHIFT_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SHIFT_WORDS - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pend_q, pend_d;
  logic              cap_q, cap_d;
  logic              sen_q, sen_d;
  logic              fiv_q, fiv_d;
  logic [WORD_W-1:0] word_q;
  logic              word_en;
  logic              shift_now, last_word;

  always_comb begin
    shift_now = mode_i & stb_i.data & ~pend_q;
    last_word = (cnt_q == LAST);
    sen_d     = shift_now;
    fiv_d     = ~mode_i & stb_i.data;
    word_en   = shift_now | fiv_d;
    pend_d    = shift_now & last_word;
    cap_d     = mode_i & ~stb_i.leave & (pend_q | stb_i.capture);

    cnt_d = cnt_q;
    if (~mode_i | stb_i.capture | stb_i.enter) cnt_d = '0;
    else if (shift_now)                        cnt_d = last_word ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      cap_q  <= 1'b0;
      sen_q  <= 1'b0;
      fiv_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      cap_q  <= cap_d;
      sen_q  <= sen_d;
      fiv_q  <= fiv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_i;
  end

  assign tile_valid_o = fiv_q;
  assign tile_word_o  = word_q;
  assign scan_en_o    = sen_q;
  assign capture_o    = cap_q;

  // R8: the capture slot never overlaps a shift cycle
  p_shift_excl_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_en_o && capture_o));
  // R5: shifting happens only in test mode
  p_shift_in_test_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en_o |-> mode_i);
  // R2: the functional strobe is never raised in test mode
  p_func_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tile_valid_o |-> !mode_i);
  // R9: a pending capture swallows the next word without a shift
  p_pending_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && mode_i && !stb_i.leave) |=> (capture_o && !scan_en_o));
endmodule

// File: rtl/tw_resp_pack.sv
module tw_resp_pack #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              scan_en_i,
  input  logic              capture_i,
  input  logic [WORD_W-1:0] scan_out_i,
  input  logic              func_valid_i,
  input  logic [WORD_W-1:0] func_word_i,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_word_o
);
  logic              ov_q, ov_d;
  logic [WORD_W-1:0] ow_q, ow_d;

  always_comb begin
    ov_d = mode_i ? (scan_en_i | capture_i) : func_valid_i;
    ow_d = (mode_i & scan_en_i) ? scan_out_i : func_word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_q <= 1'b0;
    else        ov_q <= ov_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ow_q <= '0;
    else if (ov_d) ow_q <= ow_d;
  end

  assign out_valid_o = ov_q;
  assign out_word_o  = ow_q;

  // R6: each shift cycle yields a response word one clock later
  p_resp_follows_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en_i |=> out_valid_o);
  // R10: a capture slot yields a response word one clock later
  p_resp_follows_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> out_valid_o);
endmodule

// File: rtl/tile_mode_wrapper.sv
module tile_mode_wrapper
  import tw_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int SHIFT_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              net_in_valid,
  input  logic              net_in_is_cmd,
  input  logic [WORD_W-1:0] net_in_word,
  output logic              net_out_valid,
  output logic [WORD_W-1:0] net_out_word,
  output logic              tile_in_valid,
  output logic [WORD_W-1:0] tile_in_word,
  input  logic              tile_out_valid,
  input  logic [WORD_W-1:0] tile_out_word,
  output logic              tile_test_mode,
  output logic              scan_enable,
  output logic              scan_capture,
  output logic [WORD_W-1:0] scan_in_bits,
  input  logic [WORD_W-1:0] scan_out_bits
);
  localparam int CHAINS = WORD_W;

  logic              rst_sync_n;
  strobe_t           stb;
  logic              mode_q;
  logic [WORD_W-1:0] held_word;

  tw_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  tw_cmd_decode u_dec (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .in_valid    (net_in_valid),
    .in_is_cmd   (net_in_is_cmd),
    .op_bits     (net_in_word[OP_W-1:0]),
    .stb_o       (stb),
    .test_mode_o (mode_q)
  );

  tw_scan_seq #(.WORD_W(WORD_W), .SHIFT_WORDS(SHIFT_WORDS)) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .stb_i        (stb),
    .mode_i       (mode_q),
    .word_i       (net_in_word),
    .tile_valid_o (tile_in_valid),
    .tile_word_o  (held_word),
    .scan_en_o    (scan_enable),
    .capture_o    (scan_capture)
  );

  tw_resp_pack #(.WORD_W(WORD_W)) u_resp (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .mode_i       (mode_q),
    .scan_en_i    (scan_enable),
    .capture_i    (scan_capture),
    .scan_out_i   (scan_out_bits),
    .func_valid_i (tile_out_valid),
    .func_word_i  (tile_out_word),
    .out_valid_o  (net_out_valid),
    .out_word_o   (net_out_word)
  );

  // chain i takes bit i of the held stimulus word
  for (genvar ch = 0; ch < CHAINS; ch++) begin : g_chain
    assign scan_in_bits[ch] = held_word[ch];
  end

  assign tile_in_word   = held_word;
  assign tile_test_mode = mode_q;

  // R7: idle test-mode cycles send nothing to the network
  p_func_blocked_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tile_test_mode && !scan_enable && !scan_capture) |=> !net_out_valid);
  // R4: command words never reach the tile as data
  p_cmd_silent_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (net_in_valid && net_in_is_cmd) |=> !tile_in_valid);
  // R12: leaving test mode also cancels a due capture slot
  p_leave_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (net_in_valid && net_in_is_cmd && net_in_word[1:0] == 2'd2)
      |=> (!tile_test_mode && !scan_capture));
endmodule

// File: tb/tile_mode_wrapper_bench.sv
`timescale 1ns/1ps
module tile_mode_wrapper_bench;
  localparam int W   = 32;
  localparam int NSH = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         net_in_valid, net_in_is_cmd;
  logic [W-1:0] net_in_word;
  logic         net_out_valid;
  logic [W-1:0] net_out_word;
  logic         tile_in_valid;
  logic [W-1:0] tile_in_word;
  logic         tile_out_valid;
  logic [W-1:0] tile_out_word;
  logic         tile_test_mode, scan_enable, scan_capture;
  logic [W-1:0] scan_in_bits, scan_out_bits;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tile_mode_wrapper #(.WORD_W(W), .SHIFT_WORDS(NSH)) u_tile_mode_wrapper (
    .clk(clk), .rst_n(rst_n),
    .net_in_valid(net_in_valid), .net_in_is_cmd(net_in_is_cmd), .net_in_word(net_in_word),
    .net_out_valid(net_out_valid), .net_out_word(net_out_word),
    .tile_in_valid(tile_in_valid), .tile_in_word(tile_in_word),
    .tile_out_valid(tile_out_valid), .tile_out_word(tile_out_word),
    .tile_test_mode(tile_test_mode), .scan_enable(scan_enable), .scan_capture(scan_capture),
    .scan_in_bits(scan_in_bits), .scan_out_bits(scan_out_bits)
  );

  // {valid, is_cmd, word[31:0], tile_out_valid, tile_out_word[31:0]}
  localparam logic [66:0] VEC [8] = '{
    {1'b1, 1'b0, 32'hA5A5_0001, 1'b1, 32'h1111_2222},
    {1'b0, 1'b0, 32'h0000_0000, 1'b0, 32'h3333_4444},
    {1'b1, 1'b1, 32'h0000_0000, 1'b1, 32'h5555_6666},
    {1'b1, 1'b1, 32'h0000_0002, 1'b1, 32'h7777_8888},
    {1'b1, 1'b1, 32'h0000_0003, 1'b0, 32'h9999_AAAA},
    {1'b1, 1'b0, 32'h0123_4567, 1'b1, 32'hBBBB_CCCC},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, 32'hDDDD_EEEE},
    {1'b0, 1'b0, 32'hDEAD_BEEF, 1'b1, 32'h0F0F_F0F0}
  };

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input logic v, input logic c, input logic [W-1:0] w);
    net_in_valid  = v;
    net_in_is_cmd = c;
    net_in_word   = w;
  endtask

  task automatic burst(input int n, input logic [W-1:0] seed);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] w;
      w = seed + W'(i) * 32'h0010_0001;
      put(1'b1, 1'b0, w);
      cyc();
      chk("R5", "burst scan_enable", W'(scan_enable), W'(1));
      chk("R5", "burst scan_in_bits", scan_in_bits, w);
      chk("R8", "burst no capture", W'(scan_capture), W'(0));
    end
    put(1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] wv[NSH];
    logic [W-1:0] sv[NSH];
    rst_n = 1'b0;
    put(1'b0, 1'b0, '0);
    tile_out_valid = 1'b0;
    tile_out_word  = '0;
    scan_out_bits  = '0;
    repeat (3) cyc();
    chk("R1", "reset test_mode", W'(tile_test_mode), W'(0));
    chk("R1", "reset scan_enable", W'(scan_enable), W'(0));
    chk("R1", "reset capture", W'(scan_capture), W'(0));
    chk("R1", "reset tile_in_valid", W'(tile_in_valid), W'(0));
    chk("R1", "reset net_out_valid", W'(net_out_valid), W'(0));
    rst_n = 1'b1;
    repeat (3) cyc();
    chk("R1", "post-reset test_mode", W'(tile_test_mode), W'(0));

    // functional-mode vector walk: R2, R3, R4, R11
    foreach (VEC[k]) begin
      logic v, c, fov, exp_fiv;
      logic [W-1:0] w, fod;
      {v, c, w, fov, fod} = VEC[k];
      put(v, c, w);
      tile_out_valid = fov;
      tile_out_word  = fod;
      exp_fiv = v & ~c;
      cyc();
      chk("R2", "tile_in_valid", W'(tile_in_valid), W'(exp_fiv));
      if (exp_fiv) chk("R2", "tile_in_word", tile_in_word, w);
      chk("R3", "net_out_valid", W'(net_out_valid), W'(fov));
      if (fov) chk("R3", "net_out_word", net_out_word, fod);
      chk("R11", "func-mode cmd ignored test_mode", W'(tile_test_mode), W'(0));
      chk("R11", "func-mode cmd ignored capture", W'(scan_capture), W'(0));
      chk("R4", "func-mode scan_enable", W'(scan_enable), W'(0));
    end

    // enter test mode while the tile keeps offering functional output
    tile_out_valid = 1'b1;
    tile_out_word  = 32'hCAFE_0000;
    put(1'b1, 1'b1, 32'h0000_0001);
    cyc();
    chk("R4", "enter test_mode", W'(tile_test_mode), W'(1));
    chk("R4", "enter no tile strobe", W'(tile_in_valid), W'(0));

    for (int k = 0; k < NSH; k++) begin
      wv[k] = 32'h8000_0001 ^ (W'(k) * 32'h0101_0101);
      sv[k] = ~wv[k] ^ 32'h00FF_0000;
    end
    for (int k = 0; k < NSH; k++) begin
      put(1'b1, 1'b0, wv[k]);
      if (k > 0) scan_out_bits = sv[k-1];
      cyc();
      chk("R5", "scan_enable", W'(scan_enable), W'(1));
      chk("R5", "scan_in_bits", scan_in_bits, wv[k]);
      chk("R5", "primary inputs", tile_in_word, wv[k]);
      chk("R5", "no functional strobe", W'(tile_in_valid), W'(0));
      chk("R8", "no early capture", W'(scan_capture), W'(0));
      if (k == 0) begin
        chk("R7", "func output blocked", W'(net_out_valid), W'(0));
      end else begin
        chk("R6", "response valid", W'(net_out_valid), W'(1));
        chk("R6", "response word", net_out_word, sv[k-1]);
      end
    end
    // word offered at the edge that opens the capture slot is dropped
    put(1'b1, 1'b0, 32'h5A5A_5A5A);
    scan_out_bits = sv[NSH-1];
    cyc();
    chk("R8", "capture slot", W'(scan_capture), W'(1));
    chk("R8", "capture scan_enable low", W'(scan_enable), W'(0));
    chk("R6", "last response valid", W'(net_out_valid), W'(1));
    chk("R6", "last response word", net_out_word, sv[NSH-1]);
    put(1'b0, 1'b0, '0);
    tile_out_word = 32'h600D_D00D;
    cyc();
    chk("R9", "dropped word no shift", W'(scan_enable), W'(0));
    chk("R9", "dropped word not loaded", scan_in_bits, wv[NSH-1]);
    chk("R8", "capture one cycle", W'(scan_capture), W'(0));
    chk("R10", "PO response valid", W'(net_out_valid), W'(1));
    chk("R10", "PO response word", net_out_word, 32'h600D_D00D);
    cyc();
    chk("R7", "idle test cycle blocked", W'(net_out_valid), W'(0));

    // count not advanced by the dropped word: capture after exactly NSH
    burst(NSH, 32'h1357_0000);
    cyc();
    chk("R9", "count intact capture", W'(scan_capture), W'(1));
    cyc();

    // capture command restarts the count
    burst(2, 32'h2468_0000);
    cyc();
    chk("R11", "no capture after 2", W'(scan_capture), W'(0));
    put(1'b1, 1'b1, 32'h0000_0003);
    cyc();
    chk("R11", "forced capture", W'(scan_capture), W'(1));
    chk("R11", "forced capture no shift", W'(scan_enable), W'(0));
    put(1'b0, 1'b0, '0);
    cyc();
    chk("R10", "forced capture response", W'(net_out_valid), W'(1));
    burst(NSH - 1, 32'h3690_0000);
    cyc();
    chk("R11", "restarted count short", W'(scan_capture), W'(0));
    burst(1, 32'h4000_0000);
    cyc();
    chk("R11", "restarted count full", W'(scan_capture), W'(1));
    cyc();

    // leave at the edge where a capture was due
    burst(NSH, 32'h7000_0000);
    put(1'b1, 1'b1, 32'h0000_0002);
    cyc();
    chk("R12", "leave test_mode", W'(tile_test_mode), W'(0));
    chk("R12", "due capture cancelled", W'(scan_capture), W'(0));
    put(1'b1, 1'b0, 32'h0BAD_F00D);
    tile_out_valid = 1'b1;
    tile_out_word  = 32'h1234_ABCD;
    cyc();
    chk("R12", "functional in restored", W'(tile_in_valid), W'(1));
    chk("R12", "functional in word", tile_in_word, 32'h0BAD_F00D);
    chk("R12", "functional out restored", W'(net_out_valid), W'(1));
    chk("R12", "functional out word", net_out_word, 32'h1234_ABCD);
    put(1'b0, 1'b0, '0);
    tile_out_valid = 1'b0;

    // asynchronous reset while in test mode
    put(1'b1, 1'b1, 32'h0000_0001);
    cyc();
    put(1'b0, 1'b0, '0);
    chk("R4", "re-enter", W'(tile_test_mode), W'(1));
    rst_n = 1'b0;
    #1;
    chk("R1", "async reset test_mode", W'(tile_test_mode), W'(0));
    chk("R1", "async reset net_out_valid", W'(net_out_valid), W'(0));
    cyc();
    rst_n = 1'b1;
    repeat (3) cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule